// File: doc/BRIEF.md
# Address-Range Access Guard

The guard sits on the request path between a bus master and a set of memory and peripheral regions. Every request is classified in the same cycle it is presented. Allowed requests pass through to the target unchanged, and the target's ready is returned to the master. Faulting requests never reach the target. The guard answers a faulting request itself, raising ready and error together.

Three conditions make a request fault. The address may hit no region. It may hit a region whose runtime disable bit is set. Or it may be a write or erase to a flash sector inside the protected range, which always starts at sector 0.

The first fault is recorded, with its address and a kind code. The record is kept until an acknowledge clears it. Region disable bits and the protected sector count are plain configuration inputs, driven by registers elsewhere in the chip.

Top module: `access_guard`

## Requirements
- R1: Region i (0..7) occupies the address slot whose top four bits equal i and is 2^(16+i) bytes long from the slot base. Region 0 is flash. Any address with top-nibble value 8 to 15, or past the end of its region, is unmapped. An unmapped address faults with kind code 2.
- R2: An access to a mapped region whose bit in `region_dis_i` (bit i for region i) is set faults with kind code 1.
- R3: Clearing a region's disable bit makes the next access to that region pass to the target again.
- R4: The flash sector index is address bits [15:8] (256-byte sectors). A write or erase to flash with a sector index below `prot_cnt_i` faults with kind code 3, while a read of the same sector passes.
- R5: With `prot_cnt_i` = 0 no sector is protected. The sector whose index equals `prot_cnt_i` is not protected.
- R6: On a faulting request, `tgt_valid_o` stays low and `rsp_ready_o` and `rsp_err_o` are both high in that same cycle.
- R7: On an allowed request, `tgt_valid_o` follows `req_valid_i`, `rsp_ready_o` follows `tgt_ready_i` and `rsp_err_o` is low. Address and command pass through.
- R8: The clock edge after a fault, with no record pending, sets `fault_pend_o` and captures the address and kind. Further faults while a record is pending leave the record unchanged.
- R9: `fault_ack_i` clears the record at the next edge. If a fault arrives in the same cycle as the acknowledge, that new fault is recorded instead.
- R10: After reset, `fault_pend_o`, `fault_addr_o` and `fault_kind_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Master request valid |
| req_addr_i | input | 32 | Master request address |
| req_write_i | input | 1 | Request is a write |
| req_erase_i | input | 1 | Request is a sector erase |
| rsp_ready_o | output | 1 | Response ready to master |
| rsp_err_o | output | 1 | Bus error response to master |
| tgt_valid_o | output | 1 | Forwarded request valid |
| tgt_addr_o | output | 32 | Forwarded address |
| tgt_write_o | output | 1 | Forwarded write flag |
| tgt_erase_o | output | 1 | Forwarded erase flag |
| tgt_ready_i | input | 1 | Target ready |
| region_dis_i | input | 8 | Per-region disable bits |
| prot_cnt_i | input | 9 | Number of protected flash sectors from sector 0 |
| fault_ack_i | input | 1 | Clears the fault record |
| fault_pend_o | output | 1 | Fault record pending |
| fault_addr_o | output | 32 | Address of recorded fault |
| fault_kind_o | output | 2 | Kind of recorded fault: 0 none, 1 disabled, 2 unmapped, 3 protected |

## Verification
Some rules are checked by assertions on every cycle:
- a faulting request is never forwarded and is always answered with ready and error together;
- an allowed request always reaches the target;
- a zero sector count never blocks;
- a top-nibble address of 8 or above never maps;
- a pending record stays stable until acknowledged.

Other behaviour needs the bench's scenarios. These cover the exact region edges, such as the last word of region 7 and the first byte past region 0. They also cover the sector boundary at the count, the read-versus-write split inside protected sectors, re-enabling a region, and the ordering when an acknowledge and a new fault coincide.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;
  typedef enum logic [1:0] {
    FK_NONE     = 2'd0,
    FK_DISABLED = 2'd1,
    FK_UNMAPPED = 2'd2,
    FK_PROTECT  = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/region_decode.sv
module region_decode #(
  parameter int ADDR_W         = 32,
  parameter int NUM_REGIONS    = 8,
  parameter int BASE_SIZE_LOG2 = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NUM_REGIONS-1:0] dis_i,
  output logic [NUM_REGIONS-1:0] hit_o,
  output logic                   mapped_o,
  output logic                   disabled_o
);
  localparam int IDX_W    = $clog2(NUM_REGIONS);
  localparam int SLOT_W   = IDX_W + 1;
  localparam int SLOT_LSB = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0]   slot;
  logic [SLOT_LSB-1:0] offs;

  assign slot = addr_i[ADDR_W-1:SLOT_LSB];
  assign offs = addr_i[SLOT_LSB-1:0];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    // region i spans 2^(BASE_SIZE_LOG2+i) bytes from its slot base
    assign hit_o[i] = (slot == SLOT_W'(i)) && ((offs >> (BASE_SIZE_LOG2 + i)) == '0);
  end

  assign mapped_o   = |hit_o;
  assign disabled_o = |(hit_o & dis_i);

  p_upper_unmapped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot[SLOT_W-1] |-> !mapped_o);
  p_single_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W      = 32,
  parameter int FLASH_LOG2  = 16,
  parameter int SECTOR_LOG2 = 8,
  parameter int CNT_W       = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flash_hit_i,
  input  logic              write_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              blocked_o
);
  localparam int SEC_W = FLASH_LOG2 - SECTOR_LOG2;

  logic [SEC_W-1:0] sector;
  logic             below;

  assign sector    = addr_i[FLASH_LOG2-1:SECTOR_LOG2];
  assign below     = CNT_W'(sector) < cnt_i;
  assign blocked_o = flash_hit_i && (write_i || erase_i) && below;

  p_zero_count_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !blocked_o);
  p_reads_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_i && !erase_i) |-> !blocked_o);
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import access_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  fault_kind_e       kind_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output fault_kind_e       kind_o
);
  logic take;
  assign take = fault_i && (!pend_o || ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      addr_o <= '0;
      kind_o <= FK_NONE;
    end else if (take) begin
      pend_o <= 1'b1;
      addr_o <= addr_i;
      kind_o <= kind_i;
    end else if (ack_i) begin
      pend_o <= 1'b0;
      addr_o <= '0;
      kind_o <= FK_NONE;
    end
  end

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !pend_o) |=> pend_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> (pend_o && $stable(addr_o) && $stable(kind_o)));
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !fault_i) |=> !pend_o);
endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int NUM_REGIONS    = 8,
  parameter int BASE_SIZE_LOG2 = 16,
  parameter int FLASH_REGION   = 0,
  parameter int SECTOR_LOG2    = 8,
  parameter int CNT_W          = $clog2((1 << (BASE_SIZE_LOG2 + FLASH_REGION - SECTOR_LOG2)) + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic                   req_write_i,
  input  logic                   req_erase_i,
  output logic                   rsp_ready_o,
  output logic                   rsp_err_o,
  output logic                   tgt_valid_o,
  output logic [ADDR_W-1:0]      tgt_addr_o,
  output logic                   tgt_write_o,
  output logic                   tgt_erase_o,
  input  logic                   tgt_ready_i,
  input  logic [NUM_REGIONS-1:0] region_dis_i,
  input  logic [CNT_W-1:0]       prot_cnt_i,
  input  logic                   fault_ack_i,
  output logic                   fault_pend_o,
  output logic [ADDR_W-1:0]      fault_addr_o,
  output logic [1:0]             fault_kind_o
);
  localparam int FLASH_LOG2 = BASE_SIZE_LOG2 + FLASH_REGION;

  logic [NUM_REGIONS-1:0] hit;
  logic                   mapped, disabled, prot_block, bad;
  fault_kind_e            kind, rec_kind;

  region_decode #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .BASE_SIZE_LOG2(BASE_SIZE_LOG2)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(req_addr_i), .dis_i(region_dis_i),
    .hit_o(hit), .mapped_o(mapped), .disabled_o(disabled)
  );

  sector_guard #(
    .ADDR_W(ADDR_W), .FLASH_LOG2(FLASH_LOG2), .SECTOR_LOG2(SECTOR_LOG2), .CNT_W(CNT_W)
  ) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .flash_hit_i(hit[FLASH_REGION]),
    .write_i(req_write_i), .erase_i(req_erase_i), .addr_i(req_addr_i),
    .cnt_i(prot_cnt_i), .blocked_o(prot_block)
  );

  // priority: unmapped, then disabled, then sector protection
  always_comb begin
    if (!mapped)        kind = FK_UNMAPPED;
    else if (disabled)  kind = FK_DISABLED;
    else if (prot_block) kind = FK_PROTECT;
    else                kind = FK_NONE;
  end

  assign bad         = req_valid_i && (kind != FK_NONE);
  assign tgt_valid_o = req_valid_i && (kind == FK_NONE);
  assign tgt_addr_o  = req_addr_i;
  assign tgt_write_o = req_write_i;
  assign tgt_erase_o = req_erase_i;
  assign rsp_ready_o = bad ? 1'b1 : tgt_ready_i;
  assign rsp_err_o   = bad;

  fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(bad), .addr_i(req_addr_i),
    .kind_i(kind), .ack_i(fault_ack_i), .pend_o(fault_pend_o),
    .addr_o(fault_addr_o), .kind_o(rec_kind)
  );
  assign fault_kind_o = rec_kind;

  p_blocked_no_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rsp_err_o) |-> (!tgt_valid_o && rsp_ready_o));
  p_allowed_fwd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rsp_err_o) |-> tgt_valid_o);
  p_err_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!rsp_err_o && !tgt_valid_o));
endmodule

// File: tb/access_guard_test.sv
`timescale 1ns/1ps
module access_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0, req_erase = 1'b0;
  logic        rsp_ready, rsp_err, tgt_valid, tgt_write, tgt_erase;
  logic [31:0] tgt_addr;
  logic        tgt_ready = 1'b0;
  logic [7:0]  region_dis = '0;
  logic [8:0]  prot_cnt = '0;
  logic        fault_ack = 1'b0;
  logic        fault_pend;
  logic [31:0] fault_addr;
  logic [1:0]  fault_kind;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  access_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_erase_i(req_erase), .rsp_ready_o(rsp_ready),
    .rsp_err_o(rsp_err), .tgt_valid_o(tgt_valid), .tgt_addr_o(tgt_addr),
    .tgt_write_o(tgt_write), .tgt_erase_o(tgt_erase), .tgt_ready_i(tgt_ready),
    .region_dis_i(region_dis), .prot_cnt_i(prot_cnt), .fault_ack_i(fault_ack),
    .fault_pend_o(fault_pend), .fault_addr_o(fault_addr), .fault_kind_o(fault_kind)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at a negedge, evaluate combinational response
  task automatic drive(input logic [31:0] a, input logic w, input logic e, input logic rdy);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_erase = e; tgt_ready = rdy;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_erase = 1'b0; fault_ack = 1'b0;
    #1;
  endtask

  task automatic expect_block(input string req);
    chk({req, " err"}, rsp_err, 1);
    chk({req, " ready"}, rsp_ready, 1);
    chk({req, " tgt_valid"}, tgt_valid, 0);
  endtask

  task automatic expect_pass(input string req, input logic rdy);
    chk({req, " err"}, rsp_err, 0);
    chk({req, " tgt_valid"}, tgt_valid, 1);
    chk({req, " ready follows"}, rsp_ready, rdy);
  endtask

  task automatic ack_clear();
    @(negedge clk); fault_ack = 1'b1;
    @(negedge clk); fault_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 pend", fault_pend, 0);
    chk("R10 addr", fault_addr, 0);
    chk("R10 kind", fault_kind, 0);
  endtask

  task automatic t_pass_through();
    drive(32'h1000_0040, 1'b1, 1'b0, 1'b0);
    expect_pass("R7 wait", 1'b0);
    chk("R7 addr", tgt_addr, 32'h1000_0040);
    chk("R7 write", tgt_write, 1);
    tgt_ready = 1'b1; #1;
    expect_pass("R7 ready", 1'b1);
    drive(32'h707F_FFFC, 1'b0, 1'b0, 1'b1);
    expect_pass("R1 last word region7", 1'b1);
    idle();
  endtask

  task automatic t_unmapped();
    drive(32'h9000_0000, 1'b0, 1'b0, 1'b0);
    expect_block("R1 R6 top nibble 9");
    idle();
    chk("R8 pend", fault_pend, 1);
    chk("R1 kind", fault_kind, 2);
    chk("R8 addr", fault_addr, 32'h9000_0000);
    ack_clear();
    drive(32'h0001_0000, 1'b0, 1'b0, 1'b0);
    expect_block("R1 past region0");
    drive(32'h7080_0000, 1'b0, 1'b0, 1'b0);
    expect_block("R1 past region7");
    idle();
    chk("R8 first kept", fault_addr, 32'h0001_0000);
    ack_clear();
    chk("R9 cleared", fault_pend, 0);
  endtask

  task automatic t_disable();
    region_dis = 8'b0000_0100;
    drive(32'h2000_1000, 1'b0, 1'b0, 1'b1);
    expect_block("R2 region2 disabled");
    idle();
    chk("R2 kind", fault_kind, 1);
    drive(32'h3000_0000, 1'b0, 1'b0, 1'b1);
    expect_pass("R2 other region", 1'b1);
    region_dis = '0; #1;
    expect_pass("R3", 1'b1);
    drive(32'h2000_1000, 1'b1, 1'b0, 1'b1);
    expect_pass("R3 reenabled", 1'b1);
    idle();
    ack_clear();
  endtask

  task automatic t_sectors();
    prot_cnt = 9'd4;
    drive(32'h0000_0300, 1'b1, 1'b0, 1'b1);
    expect_block("R4 write sector3");
    idle();
    chk("R4 kind", fault_kind, 3);
    ack_clear();
    drive(32'h0000_0000, 1'b0, 1'b1, 1'b1);
    expect_block("R4 erase sector0");
    drive(32'h0000_0310, 1'b0, 1'b0, 1'b1);
    expect_pass("R4 read sector3", 1'b1);
    drive(32'h0000_0400, 1'b1, 1'b0, 1'b1);
    expect_pass("R5 sector at count", 1'b1);
    prot_cnt = 9'd0;
    drive(32'h0000_0000, 1'b0, 1'b1, 1'b1);
    expect_pass("R5 count zero", 1'b1);
    prot_cnt = 9'd256;
    drive(32'h0000_FF00, 1'b1, 1'b0, 1'b1);
    expect_block("R4 full range");
    idle();
    ack_clear();
    prot_cnt = 9'd0;
  endtask

  task automatic t_ack_collide();
    drive(32'hA000_0000, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R8 pend", fault_pend, 1);
    drive(32'hB000_0004, 1'b0, 1'b0, 1'b0);
    fault_ack = 1'b1;
    idle();
    chk("R9 new record pend", fault_pend, 1);
    chk("R9 new record addr", fault_addr, 32'hB000_0004);
    ack_clear();
    chk("R9 clear pend", fault_pend, 0);
    chk("R9 clear kind", fault_kind, 0);
  endtask

  initial begin
    #100_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_pass_through();
    t_unmapped();
    t_disable();
    t_sectors();
    t_ack_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule